// File: doc/BRIEF.md
# Three-Level BCD Power Setpoint Counter

This block holds three separate power setpoints, one each for the high, medium and low operating levels. Each setpoint is a three-digit decimal value stored as BCD, from 000 to 999. An operator raises or lowers the setpoint of the currently selected level. A slow step rate paces the adjustment so the value moves gradually. That step rate comes from an internal divider driven by a faster tick at debounce rate.

A step reaches a level's counter only when four things are true: the level is selected, the transmitter is on, exactly one direction is requested, and that level's limit does not block the direction. Each counter stops at 000 and at 999 instead of wrapping around. Every step that is accepted produces a one-clock data strobe, delayed so that a downstream latch captures the value after it has settled. A clear input, which may also be driven by a supply-low detector, returns every setpoint to 000 and restarts the divider.

Top module: `pwr_setpoint_bank`

## Requirements
- R1: While `rst_n` is low, or in the clock cycle after `clr` is sampled high, all three setpoints read 0x000, `at_min` reads 3'b111, `at_max` reads 3'b000 and `data_strobe` reads 0. `clr` wins over a step in the same cycle.
- R2: A raise step adds one in decimal. A ones digit of 9 becomes 0 and increments the tens digit. A tens digit of 9 rolls over in turn and increments the hundreds digit (0x099 becomes 0x100). Every digit stays within 0..9.
- R3: A lower step subtracts one in decimal. A ones digit of 0 becomes 9 and borrows from the tens digit, which borrows from the hundreds digit in the same way (0x100 becomes 0x099).
- R4: The step rate is one step per `DIV_RATIO` pulses of `fast_tick` (default 8). The setpoint changes in the clock cycle after the `DIV_RATIO`-th pulse counted since the last step or clear. `clr` restarts this count.
- R5: A step changes only the level whose `level_sel` bit is set (bit 0 high, bit 1 medium, bit 2 low), and only while `tx_on` is 1. With `tx_on` at 0, or with no level selected, no setpoint changes.
- R6: When `raise_req` and `lower_req` are both 1, no setpoint changes and no strobe is issued.
- R7: A setpoint at 0x999 does not increase, and a setpoint at 0x000 does not decrease. `at_max[i]` is 1 exactly when level i reads 0x999, and `at_min[i]` is 1 exactly when it reads 0x000. The high limit blocks only raising, and the low limit blocks only lowering.
- R8: Each accepted step produces `data_strobe` high for exactly one clock cycle, one cycle after the setpoint changes. A blocked step produces no strobe.
- R9: When `level_sel` has more than one bit set, no setpoint changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all setpoints and the divider (supply-low reset) |
| fast_tick | input | 1 | One-cycle pulse at debounce rate |
| raise_req | input | 1 | Request to count up |
| lower_req | input | 1 | Request to count down |
| level_sel | input | 3 | One-hot level select: bit 0 high, bit 1 medium, bit 2 low |
| tx_on | input | 1 | Transmitter-on enable |
| setpoint_hi | output | 12 | High-level setpoint as three BCD digits, hundreds in bits 11:8 |
| setpoint_med | output | 12 | Medium-level setpoint as three BCD digits |
| setpoint_lo | output | 12 | Low-level setpoint as three BCD digits |
| at_max | output | 3 | Per-level flag, 1 when the setpoint reads 999 |
| at_min | output | 3 | Per-level flag, 1 when the setpoint reads 000 |
| data_strobe | output | 1 | One-cycle latch strobe, one cycle after each accepted step |

## Verification
The assertions check on every cycle that each digit stays in decimal range, that a counter holds when it gets no step, that clear empties it, that a step never reaches a counter sitting at the limit in that direction, that conflicting requests or a multi-bit select never let a step through, and that every step is followed two cycles later by the strobe. Some behaviour only the bench scenarios can show. These are the decimal carry and borrow across digit boundaries, the exact cycle of a change relative to the divider and its restart, the isolation between levels, and saturation after a thousand steps.

// File: rtl/pwrset_pkg.sv
package pwrset_pkg;
  localparam int NLEVEL = 3;
  localparam int DIGITS = 3;
  localparam int VAL_W  = 4 * DIGITS;

  typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_UP = 2'd1, DIR_DOWN = 2'd2} step_dir_e;

  function automatic logic [3:0] digit_next_up(input logic [3:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic [3:0] digit_next_down(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction

  function automatic step_dir_e decode_dir(input logic up, input logic dn);
    if (up && !dn) return DIR_UP;
    if (dn && !up) return DIR_DOWN;
    return DIR_NONE;
  endfunction
endpackage

// File: rtl/step_divider.sv
module step_divider #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fast_tick,
  output logic step_fire
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] tick_cnt;
  logic          at_last;

  assign at_last   = (tick_cnt == LAST);
  assign step_fire = fast_tick && at_last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_cnt <= '0;
    else if (clr)
      tick_cnt <= '0;
    else if (fast_tick)
      tick_cnt <= at_last ? '0 : tick_cnt + 1'b1;
  end

  p_fire_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> fast_tick);
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= LAST);
  p_clear_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tick_cnt == '0));
endmodule

// File: rtl/bcd_level_counter.sv
module bcd_level_counter
  import pwrset_pkg::*;
#(
  parameter int ND = DIGITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            up_step,
  input  logic            dn_step,
  output logic [4*ND-1:0] value,
  output logic            is_max,
  output logic            is_min
);
  // true when every digit below position k equals d
  function automatic logic lower_digits_are(input logic [4*ND-1:0] v,
                                            input int k, input logic [3:0] d);
    logic r;
    r = 1'b1;
    for (int j = 0; j < ND; j++)
      if (j < k && v[4*j +: 4] != d) r = 1'b0;
    return r;
  endfunction

  function automatic logic all_digits_are(input logic [4*ND-1:0] v, input logic [3:0] d);
    return lower_digits_are(v, ND, d);
  endfunction

  assign is_max = all_digits_are(value, 4'd9);
  assign is_min = (value == '0);

  for (genvar k = 0; k < ND; k++) begin : g_digit
    logic [3:0] d_q;
    logic       inc_here, dec_here;

    assign inc_here = up_step && lower_digits_are(value, k, 4'd9);
    assign dec_here = dn_step && lower_digits_are(value, k, 4'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        d_q <= 4'd0;
      else if (clr)      d_q <= 4'd0;
      else if (inc_here) d_q <= digit_next_up(d_q);
      else if (dec_here) d_q <= digit_next_down(d_q);
    end

    assign value[4*k +: 4] = d_q;

    p_digit_decimal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      d_q <= 4'd9);
  end

  p_no_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_step || dn_step || clr) |=> $stable(value));
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));
  p_no_raise_past_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_step |-> !is_max);
  p_no_lower_past_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_step |-> !is_min);
  p_single_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_step && dn_step));
endmodule

// File: rtl/pwr_setpoint_bank.sv
module pwr_setpoint_bank
  import pwrset_pkg::*;
#(
  parameter int DIV_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fast_tick,
  input  logic             raise_req,
  input  logic             lower_req,
  input  logic [NLEVEL-1:0] level_sel,
  input  logic             tx_on,
  output logic [VAL_W-1:0] setpoint_hi,
  output logic [VAL_W-1:0] setpoint_med,
  output logic [VAL_W-1:0] setpoint_lo,
  output logic [NLEVEL-1:0] at_max,
  output logic [NLEVEL-1:0] at_min,
  output logic             data_strobe
);
  logic              step_fire;
  step_dir_e         dir;
  logic              sel_ok;
  logic [NLEVEL-1:0] route_up, route_dn;
  logic              any_step;
  logic              strobe_d1;
  logic [VAL_W-1:0]  lvl_val [NLEVEL];

  step_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fast_tick(fast_tick), .step_fire(step_fire)
  );

  assign dir    = decode_dir(raise_req, lower_req);
  assign sel_ok = $onehot(level_sel);

  for (genvar i = 0; i < NLEVEL; i++) begin : g_level
    logic gate_open;
    assign gate_open   = step_fire && tx_on && sel_ok && level_sel[i];
    assign route_up[i] = gate_open && (dir == DIR_UP)   && !at_max[i];
    assign route_dn[i] = gate_open && (dir == DIR_DOWN) && !at_min[i];

    bcd_level_counter #(.ND(DIGITS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .up_step(route_up[i]), .dn_step(route_dn[i]),
      .value(lvl_val[i]), .is_max(at_max[i]), .is_min(at_min[i])
    );
  end

  assign setpoint_hi  = lvl_val[0];
  assign setpoint_med = lvl_val[1];
  assign setpoint_lo  = lvl_val[2];

  assign any_step = |(route_up | route_dn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d1   <= 1'b0;
      data_strobe <= 1'b0;
    end else if (clr) begin
      strobe_d1   <= 1'b0;
      data_strobe <= 1'b0;
    end else begin
      strobe_d1   <= any_step;
      data_strobe <= strobe_d1;
    end
  end

  p_conflict_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && lower_req) |-> !any_step);
  p_multi_select_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(level_sel) > 1) |-> !any_step);
  p_tx_off_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> !any_step);
  p_one_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route_up | route_dn));
  p_strobe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    any_step |=> ##1 data_strobe);
endmodule

// File: tb/sim_pwr_setpoint_bank.sv
`timescale 1ns/1ps
module sim_pwr_setpoint_bank;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, fast_tick = 1'b0, raise_req = 1'b0, lower_req = 1'b0, tx_on = 1'b0;
  logic [2:0] level_sel = 3'b000;
  logic [11:0] setpoint_hi, setpoint_med, setpoint_lo;
  logic [2:0] at_max, at_min;
  logic data_strobe;

  int n_checks = 0, n_fail = 0, strobe_cnt = 0;
  int exp_val [3];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_setpoint_bank #(.DIV_RATIO(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fast_tick(fast_tick),
    .raise_req(raise_req), .lower_req(lower_req), .level_sel(level_sel), .tx_on(tx_on),
    .setpoint_hi(setpoint_hi), .setpoint_med(setpoint_med), .setpoint_lo(setpoint_lo),
    .at_max(at_max), .at_min(at_min), .data_strobe(data_strobe)
  );

  always @(posedge clk) if (data_strobe) strobe_cnt++;

  function automatic logic [11:0] to_bcd(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] level_out(input int i);
    return (i == 0) ? setpoint_hi : (i == 1) ? setpoint_med : setpoint_lo;
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < 3; i++) check(req, 32'(level_out(i)), 32'(to_bcd(exp_val[i])));
  endtask

  task automatic pulse_tick();
    @(negedge clk) fast_tick = 1'b1;
    @(negedge clk) fast_tick = 1'b0;
  endtask

  task automatic do_step();
    repeat (DIV) pulse_tick();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    for (int i = 0; i < 3; i++) exp_val[i] = 0;
  endtask

  task automatic set_req(input logic up, input logic dn, input logic [2:0] sel, input logic tx);
    @(negedge clk);
    raise_req = up; lower_req = dn; level_sel = sel; tx_on = tx;
  endtask

  // R1: reset and clear state
  task automatic t_reset_clear();
    check("R1 reset hi", 32'(setpoint_hi), 32'h0);
    check("R1 reset min", 32'(at_min), 32'b111);
    check("R1 reset max", 32'(at_max), 32'b000);
    check("R1 reset strobe", 32'(data_strobe), 32'h0);
    set_req(1, 0, 3'b010, 1);
    repeat (3) do_step();
    exp_val[1] = 3;
    check_all("R1 pre-clear");
    do_clear();
    check_all("R1 after clear");
    check("R1 min after clear", 32'(at_min), 32'b111);
  endtask

  // R2 carry and R3 borrow
  task automatic t_carry_borrow();
    do_clear();
    set_req(1, 0, 3'b001, 1);
    for (int s = 0; s < 100; s++) do_step();
    exp_val[0] = 100;
    check_all("R2 carry 099 to 100");
    set_req(0, 1, 3'b001, 1);
    do_step();
    exp_val[0] = 99;
    check_all("R3 borrow 100 to 099");
    do_step();
    exp_val[0] = 98;
    check_all("R3 ones decrement");
  endtask

  // R4 divider timing and restart
  task automatic t_divider();
    do_clear();
    set_req(1, 0, 3'b100, 1);
    repeat (DIV - 3) pulse_tick();
    do_clear();
    repeat (DIV - 1) pulse_tick();
    repeat (2) @(negedge clk);
    check_all("R4 no step before ratio after restart");
    @(negedge clk) fast_tick = 1'b1;
    @(negedge clk) fast_tick = 1'b0;
    exp_val[2] = 1;
    check_all("R4 step on ratio-th tick");
  endtask

  // R5 gating, R6 conflict, R9 multi-select
  task automatic t_gating();
    int s0;
    do_clear();
    s0 = strobe_cnt;
    set_req(1, 0, 3'b010, 0);  do_step(); check_all("R5 tx off");
    set_req(1, 0, 3'b000, 1);  do_step(); check_all("R5 no level");
    set_req(1, 1, 3'b010, 1);  do_step(); check_all("R6 both requests");
    set_req(1, 0, 3'b011, 1);  do_step(); check_all("R9 two levels");
    set_req(0, 0, 3'b010, 1);  do_step(); check_all("R5 no request");
    check("R6 no strobe when blocked", 32'(strobe_cnt - s0), 32'd0);
    set_req(1, 0, 3'b010, 1);  do_step(); exp_val[1] = 1; check_all("R5 medium only");
  endtask

  // R8 strobe timing
  task automatic t_strobe();
    int s0;
    do_clear();
    set_req(1, 0, 3'b001, 1);
    repeat (DIV - 1) pulse_tick();
    @(negedge clk) fast_tick = 1'b1;
    @(negedge clk) fast_tick = 1'b0;
    check("R8 value updated", 32'(setpoint_hi), 32'h001);
    check("R8 strobe not yet", 32'(data_strobe), 32'h0);
    @(negedge clk);
    check("R8 strobe high", 32'(data_strobe), 32'h1);
    @(negedge clk);
    check("R8 strobe one cycle", 32'(data_strobe), 32'h0);
    s0 = strobe_cnt;
    repeat (4) do_step();
    check("R8 strobe per step", 32'(strobe_cnt - s0), 32'd4);
  endtask

  // R7 saturation
  task automatic t_saturate();
    int s0;
    do_clear();
    set_req(0, 1, 3'b100, 1);
    s0 = strobe_cnt;
    do_step();
    check_all("R7 no lower below 000");
    check("R7 no strobe at min", 32'(strobe_cnt - s0), 32'd0);
    set_req(1, 0, 3'b100, 1);
    for (int s = 0; s < 999; s++) do_step();
    exp_val[2] = 999;
    check_all("R7 reach 999");
    check("R7 max flag", 32'(at_max), 32'b100);
    s0 = strobe_cnt;
    do_step();
    check_all("R7 no raise above 999");
    check("R7 no strobe at max", 32'(strobe_cnt - s0), 32'd0);
    set_req(0, 1, 3'b100, 1);
    do_step();
    exp_val[2] = 998;
    check_all("R7 lower from max");
    check("R7 max flag cleared", 32'(at_max), 32'b000);
    check("R7 min flags", 32'(at_min), 32'b011);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) exp_val[i] = 0;
    repeat (3) @(negedge clk);
    t_reset_clear_pre();
  end

  task automatic t_reset_clear_pre();
    check("R1 in reset", 32'(setpoint_lo), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    t_reset_clear();
    t_carry_borrow();
    t_divider();
    t_gating();
    t_strobe();
    t_saturate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule